// File: doc/BRIEF.md
# Channel-Transposing Memory Write Master

This block drains a per-channel sample buffer into external memory so that every channel's history lands in one contiguous region. The buffer is a dual-port memory in which word *k* holds the most recent sample of channel *k*. When a sweep is started, the block reads channels 0 through N-1 in turn. It writes each sample through an AXI4-Lite write master to an address built from the channel number and a running acquisition-cycle counter. A later streaming reader can then fetch the samples of one channel as a single linear block.

Each write is a single, non-burst transaction. At most one write is in flight at a time. The cycle counter advances once per completed sweep and wraps after its field fills, so each channel region acts as a ring of 2^IDX_W words. An error response from the slave is recorded in a sticky flag and does not stop the sweep.

Top module: `chan_scatter_wr`

## Requirements
- R1: After reset the block is idle: busy, done, error, awvalid, wvalid, bready and buf_rd_en are 0, and the cycle counter is 0, so the first sweep writes to index 0 of each region.
- R2: A start pulse with num_ch = N (1 to 2^CH_W) runs one sweep that reads buffer addresses 0, 1, …, N-1 in ascending order and performs exactly one write per channel.
- R3: The write for channel c in cycle i goes to byte address base_addr + ({c, i} << 2), where i is the low IDX_W bits and c sits directly above it (bits 15:8 for channel and 7:0 for cycle at the default sizes). The write data is the buffer word of channel c, wstrb is all ones and awprot is 0.
- R4: For each sample, buf_rd_en is high for one cycle, and awvalid and wvalid both rise two cycles later, after one cycle of read latency.
- R5: Once raised, awvalid stays high with a stable awaddr until awready is seen, and wvalid stays high with stable wdata until wready is seen.
- R6: At most one write is outstanding. bready is high only while a response is awaited, and no new address is issued before the previous B handshake.
- R7: After the B handshake of the last channel, done is high for exactly one cycle, busy falls in that same cycle, and the cycle counter increments, wrapping from 2^IDX_W-1 to 0.
- R8: A bresp of 2'b10 or 2'b11 sets the sticky error flag. Responses 2'b00 and 2'b01 do not. The sweep continues either way, and an accepted start clears the flag.
- R9: A start pulse while busy is ignored, including any new num_ch and base_addr. A start with num_ch = 0 is ignored and leaves the block idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Sweep start pulse |
| num_ch | input | CH_W+1 | Number of channels in the sweep |
| base_addr | input | ADDR_W | Byte base address of the channel-major area |
| buf_rd_en | output | 1 | Buffer read enable |
| buf_rd_addr | output | CH_W | Buffer read address (channel number) |
| buf_rd_data | input | DATA_W | Buffer read data, valid one cycle after the read |
| m_awaddr | output | ADDR_W | Write address |
| m_awprot | output | 3 | Write protection attributes (0) |
| m_awvalid | output | 1 | Write address valid |
| m_awready | input | 1 | Write address ready |
| m_wdata | output | DATA_W | Write data |
| m_wstrb | output | DATA_W/8 | Write byte strobes (all ones) |
| m_wvalid | output | 1 | Write data valid |
| m_wready | input | 1 | Write data ready |
| m_bresp | input | 2 | Write response code |
| m_bvalid | input | 1 | Write response valid |
| m_bready | output | 1 | Write response ready |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle end-of-sweep pulse |
| error | output | 1 | Sticky error-response flag |

## Verification
The bench builds the block with CH_W = 3 and IDX_W = 4. This makes every channel count from 1 to 8 cheap to sweep, and it lets the cycle counter wrap after only 16 sweeps, so the wrap in R7 and the reset in R1 are both reached. The AXI slave model varies awready, wready and bvalid timing from a shift register, so address-first, data-first and simultaneous handshakes all occur. Each of the four response codes is injected on chosen channels.

// File: rtl/chan_scatter_pkg.sv
package chan_scatter_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ,
        ST_LAT,
        ST_SEND,
        ST_RESP
    } cs_state_e;

endpackage

// File: rtl/cs_addr_gen.sv
module cs_addr_gen #(
    parameter int ADDR_W = 32,
    parameter int CH_W   = 8,
    parameter int IDX_W  = 8
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [CH_W-1:0]   ch,
    input  logic [IDX_W-1:0]  iter,
    output logic [ADDR_W-1:0] addr
);
    localparam int OFF_W = CH_W + IDX_W;

    logic [ADDR_W-1:0] word_off;

    always_comb begin
        word_off = '0;
        word_off[OFF_W+1:2] = {ch, iter};
        addr = base + word_off;
    end
endmodule

// File: rtl/cs_wr_chan.sv
module cs_wr_chan (
    input  logic clk,
    input  logic rst_n,
    input  logic launch,
    input  logic awready,
    input  logic wready,
    output logic awvalid,
    output logic wvalid,
    output logic accepted
);
    logic aw_pend_d, aw_pend_q;
    logic w_pend_d, w_pend_q;

    always_comb begin
        aw_pend_d = launch | (aw_pend_q & ~awready);
        w_pend_d  = launch | (w_pend_q & ~wready);
        accepted  = (aw_pend_q | w_pend_q) & ~aw_pend_d & ~w_pend_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            aw_pend_q <= 1'b0;
            w_pend_q  <= 1'b0;
        end else begin
            aw_pend_q <= aw_pend_d;
            w_pend_q  <= w_pend_d;
        end
    end

    assign awvalid = aw_pend_q;
    assign wvalid  = w_pend_q;
endmodule

// File: rtl/chan_scatter_wr.sv
module chan_scatter_wr
    import chan_scatter_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CH_W   = 8,
    parameter int IDX_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [CH_W:0]       num_ch,
    input  logic [ADDR_W-1:0]   base_addr,
    output logic                buf_rd_en,
    output logic [CH_W-1:0]     buf_rd_addr,
    input  logic [DATA_W-1:0]   buf_rd_data,
    output logic [ADDR_W-1:0]   m_awaddr,
    output logic [2:0]          m_awprot,
    output logic                m_awvalid,
    input  logic                m_awready,
    output logic [DATA_W-1:0]   m_wdata,
    output logic [DATA_W/8-1:0] m_wstrb,
    output logic                m_wvalid,
    input  logic                m_wready,
    input  logic [1:0]          m_bresp,
    input  logic                m_bvalid,
    output logic                m_bready,
    output logic                busy,
    output logic                done,
    output logic                error
);
    localparam int NUM_W = CH_W + 1;

    typedef struct packed {
        cs_state_e          st;
        logic [CH_W-1:0]    ch;
        logic [IDX_W-1:0]   iter;
        logic [NUM_W-1:0]   num;
        logic [ADDR_W-1:0]  base;
        logic [DATA_W-1:0]  data;
        logic               err;
        logic               done;
    } regs_t;

    regs_t r_d, r_q;
    logic  launch;
    logic  accepted;
    logic  last_ch;
    logic  bad_resp;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        launch   = 1'b0;
        last_ch  = ({1'b0, r_q.ch} == (r_q.num - 1'b1));
        bad_resp = (m_bresp == 2'b10) || (m_bresp == 2'b11);
        unique case (r_q.st)
            ST_IDLE: begin
                if (start && (num_ch != '0)) begin
                    r_d.st   = ST_READ;
                    r_d.ch   = '0;
                    r_d.num  = num_ch;
                    r_d.base = base_addr;
                    r_d.err  = 1'b0;
                end
            end
            ST_READ: r_d.st = ST_LAT;
            ST_LAT: begin
                r_d.st   = ST_SEND;
                r_d.data = buf_rd_data;
                launch   = 1'b1;
            end
            ST_SEND: begin
                if (accepted) r_d.st = ST_RESP;
            end
            ST_RESP: begin
                if (m_bvalid) begin
                    if (bad_resp) r_d.err = 1'b1;
                    if (last_ch) begin
                        r_d.st   = ST_IDLE;
                        r_d.iter = r_q.iter + 1'b1;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.st = ST_READ;
                        r_d.ch = r_q.ch + 1'b1;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    cs_addr_gen #(.ADDR_W(ADDR_W), .CH_W(CH_W), .IDX_W(IDX_W)) u_addr (
        .base (r_q.base),
        .ch   (r_q.ch),
        .iter (r_q.iter),
        .addr (m_awaddr)
    );

    cs_wr_chan u_wr (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .awready  (m_awready),
        .wready   (m_wready),
        .awvalid  (m_awvalid),
        .wvalid   (m_wvalid),
        .accepted (accepted)
    );

    assign buf_rd_en   = (r_q.st == ST_READ);
    assign buf_rd_addr = r_q.ch;
    assign m_awprot    = 3'b000;
    assign m_wdata     = r_q.data;
    assign m_wstrb     = '1;
    assign m_bready    = (r_q.st == ST_RESP);
    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign error       = r_q.err;
endmodule

// File: rtl/chan_scatter_chk.sv
module chan_scatter_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CH_W   = 8,
    parameter int IDX_W  = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [CH_W:0]       num_ch,
    input logic [ADDR_W-1:0]   base_addr,
    input logic                buf_rd_en,
    input logic [CH_W-1:0]     buf_rd_addr,
    input logic [DATA_W-1:0]   buf_rd_data,
    input logic [ADDR_W-1:0]   m_awaddr,
    input logic [2:0]          m_awprot,
    input logic                m_awvalid,
    input logic                m_awready,
    input logic [DATA_W-1:0]   m_wdata,
    input logic [DATA_W/8-1:0] m_wstrb,
    input logic                m_wvalid,
    input logic                m_wready,
    input logic [1:0]          m_bresp,
    input logic                m_bvalid,
    input logic                m_bready,
    input logic                busy,
    input logic                done,
    input logic                error
);
    logic [1:0] outst_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outst_q <= '0;
        end else if (m_awvalid && m_awready) begin
            outst_q <= (outst_q == 2'd3) ? outst_q : outst_q + 2'd1;
        end else if (m_bvalid && m_bready && outst_q != 2'd0) begin
            outst_q <= outst_q - 2'd1;
        end
    end

    a_r4_read_before_write: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(m_awvalid) |-> $past(buf_rd_en, 2));

    a_r5_aw_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));

    a_r5_w_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata)));

    a_r6_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        outst_q <= 2'd1);

    a_r6_no_aw_while_pending: assert property (@(posedge clk) disable iff (!rst_n)
        m_awvalid |-> (outst_q == 2'd0));

    a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r8_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !start) |=> error);
endmodule

bind chan_scatter_wr chan_scatter_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .IDX_W(IDX_W)
) u_chk (.*);

// File: tb/sim_chan_scatter_wr.sv
module sim_chan_scatter_wr;
    localparam int ADDR_W = 32;
    localparam int DATA_W = 32;
    localparam int CH_W   = 3;
    localparam int IDX_W  = 4;
    localparam int NCH    = 1 << CH_W;
    localparam int NIDX   = 1 << IDX_W;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [CH_W:0] num_ch = '0;
    logic [ADDR_W-1:0] base_addr = '0;
    logic buf_rd_en;
    logic [CH_W-1:0] buf_rd_addr;
    logic [DATA_W-1:0] buf_rd_data = '0;
    logic [ADDR_W-1:0] m_awaddr;
    logic [2:0] m_awprot;
    logic m_awvalid;
    logic m_awready = 1'b0;
    logic [DATA_W-1:0] m_wdata;
    logic [DATA_W/8-1:0] m_wstrb;
    logic m_wvalid;
    logic m_wready = 1'b0;
    logic [1:0] m_bresp = 2'b00;
    logic m_bvalid = 1'b0;
    logic m_bready;
    logic busy, done, error;

    always #4 clk = ~clk;

    chan_scatter_wr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CH_W(CH_W), .IDX_W(IDX_W)) u0 (.*);

    int checks = 0;
    int fails = 0;
    logic [DATA_W-1:0] bufmem [NCH];
    int exp_ch = 0;
    int exp_iter = 0;
    logic [ADDR_W-1:0] exp_base = '0;
    int nwrites = 0;
    int err_ch = -1;
    logic [1:0] err_code = 2'b00;

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // buffer memory model, one cycle read latency
    initial forever begin
        @(posedge clk);
        if (buf_rd_en) buf_rd_data <= bufmem[buf_rd_addr];
    end

    // AXI4-Lite slave model and port monitors, acting at the falling edge
    initial begin
        logic [15:0] lf = 16'hACE1;
        logic got_aw = 1'b0, got_w = 1'b0, b_fired = 1'b0;
        logic [ADDR_W-1:0] cap_addr = '0;
        logic [DATA_W-1:0] cap_data = '0;
        logic [1:0] rdh = 2'b00;
        logic aw_prev = 1'b0;
        logic aw_wait = 1'b0, w_wait = 1'b0;
        logic [ADDR_W-1:0] wait_addr = '0;
        logic [DATA_W-1:0] wait_data = '0;
        forever begin
            @(negedge clk);
            if (!rst_n) begin
                m_awready = 0; m_wready = 0; m_bvalid = 0;
                got_aw = 0; got_w = 0; b_fired = 0; rdh = 0; aw_prev = 0;
                aw_wait = 0; w_wait = 0;
                continue;
            end
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            if (b_fired) begin m_bvalid = 0; b_fired = 0; end
            // R5: held valid with stable payload
            if (aw_wait) chk(m_awvalid && m_awaddr == wait_addr, "R5 aw hold", m_awaddr, wait_addr);
            if (w_wait)  chk(m_wvalid && m_wdata == wait_data, "R5 w hold", m_wdata, wait_data);
            // R4: address phase two cycles after buffer read
            if (m_awvalid && !aw_prev) chk(rdh[1] && m_wvalid, "R4 read-to-write spacing", {rdh, m_wvalid}, 3'b101);
            aw_prev = m_awvalid;
            if (buf_rd_en) chk(buf_rd_addr == CH_W'(exp_ch), "R2 read order", buf_rd_addr, exp_ch);
            rdh = {rdh[0], buf_rd_en};
            chk(m_bready == (got_aw && got_w), "R6 bready window", m_bready, got_aw && got_w);
            m_awready = lf[0] | lf[3];
            m_wready  = lf[1] | lf[4];
            if (!m_bvalid && got_aw && got_w && lf[2]) begin
                m_bvalid = 1;
                m_bresp = (exp_ch == err_ch) ? err_code : 2'b00;
            end
            aw_wait = m_awvalid && !m_awready;
            w_wait  = m_wvalid && !m_wready;
            wait_addr = m_awaddr;
            wait_data = m_wdata;
            if (m_awvalid && m_awready) begin
                chk(!got_aw && !m_bvalid, "R6 single outstanding", got_aw, 0);
                got_aw = 1; cap_addr = m_awaddr;
                chk(m_awprot == 3'b000, "R3 awprot", m_awprot, 0);
            end
            if (m_wvalid && m_wready) begin
                got_w = 1; cap_data = m_wdata;
                chk(m_wstrb == '1, "R3 wstrb", m_wstrb, 4'hF);
            end
            if (m_bvalid && m_bready) begin
                logic [ADDR_W-1:0] ea;
                ea = exp_base + ADDR_W'(((exp_ch * NIDX) + exp_iter) * 4);
                chk(cap_addr == ea, "R3 address", cap_addr, ea);
                chk(cap_data == bufmem[exp_ch], "R3 data", cap_data, bufmem[exp_ch]);
                got_aw = 0; got_w = 0; b_fired = 1;
                exp_ch++; nwrites++;
            end
        end
    end

    task automatic fill_buf(input int salt);
        for (int i = 0; i < NCH; i++)
            bufmem[i] = 32'h5A000000 ^ (i * 32'h01030507) ^ (salt << 12) ^ (exp_iter << 4);
    endtask

    task automatic pulse_start(input int n, input logic [ADDR_W-1:0] b);
        @(negedge clk);
        start = 1; num_ch = (CH_W+1)'(n); base_addr = b;
        @(negedge clk);
        start = 0;
    endtask

    task automatic run_sweep(input int n, input logic [ADDR_W-1:0] b, input logic exp_err, input int salt);
        int t;
        int w0;
        fill_buf(salt);
        exp_base = b; exp_ch = 0; w0 = nwrites;
        pulse_start(n, b);
        t = 0;
        while (!done && t < 4000) begin @(negedge clk); t++; end
        chk(done == 1, "R7 done seen", done, 1);
        chk(busy == 0, "R7 busy falls with done", busy, 0);
        chk(nwrites - w0 == n, "R2 write count", nwrites - w0, n);
        chk(error == exp_err, "R8 error flag", error, exp_err);
        @(negedge clk);
        chk(done == 0, "R7 done one cycle", done, 0);
        exp_iter = (exp_iter + 1) % NIDX;
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int w0;
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !error, "R1 reset flags", {busy, done, error}, 0);
        chk(!m_awvalid && !m_wvalid && !m_bready && !buf_rd_en, "R1 reset handshakes",
            {m_awvalid, m_wvalid, m_bready, buf_rd_en}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2/R3: every channel count, iteration advancing
        for (int n = 1; n <= NCH; n++) run_sweep(n, 32'h1000_0000 + n * 32'h100, 0, n);

        // R8: SLVERR sets the flag, sweep continues
        err_ch = 2; err_code = 2'b10;
        run_sweep(5, 32'h2000_0000, 1, 11);
        // R8: next start clears it, EXOKAY does not set it
        err_ch = 1; err_code = 2'b01;
        fill_buf(12); exp_base = 32'h2100_0000; exp_ch = 0;
        pulse_start(3, 32'h2100_0000);
        chk(error == 0, "R8 cleared by start", error, 0);
        while (!done) @(negedge clk);
        chk(error == 0, "R8 EXOKAY no error", error, 0);
        @(negedge clk);
        exp_iter = (exp_iter + 1) % NIDX;
        // R8: DECERR on the last channel
        err_ch = 3; err_code = 2'b11;
        run_sweep(4, 32'h2200_0000, 1, 13);
        err_ch = -1;

        // R9: start while busy is ignored
        fill_buf(14); exp_base = 32'h3000_0000; exp_ch = 0; w0 = nwrites;
        pulse_start(4, 32'h3000_0000);
        repeat (3) @(negedge clk);
        pulse_start(8, 32'h3F00_0000);
        while (!done) @(negedge clk);
        chk(nwrites - w0 == 4, "R9 busy start ignored", nwrites - w0, 4);
        exp_iter = (exp_iter + 1) % NIDX;
        repeat (20) @(negedge clk);
        chk(busy == 0 && nwrites - w0 == 4, "R9 no extra sweep", nwrites - w0, 4);

        // R9: zero channel count ignored
        w0 = nwrites;
        pulse_start(0, 32'h4000_0000);
        repeat (10) @(negedge clk);
        chk(busy == 0 && nwrites == w0, "R9 zero count ignored", busy, 0);

        // R7: run past the wrap of the cycle counter
        for (int k = 0; k < NIDX + 3; k++) run_sweep(2, 32'h5000_0000, 0, 20 + k);

        // R1: reset returns counter to zero
        @(negedge clk); rst_n = 0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !error && !m_awvalid, "R1 reset again", busy, 0);
        rst_n = 1; exp_iter = 0;
        @(negedge clk);
        run_sweep(3, 32'h6000_0000, 0, 40);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule